// File: doc/BRIEF.md
# Panel Power-Up Sequencer

This block brings an LCD panel up by walking a fixed chain of stages: an initial stage with no output, then panel supply, LVDS link release, backlight supply, backlight PWM start, backlight enable, and finally a done state. After the initial stage and each of the next three, the block waits a programmable number of milliseconds. The wait is measured against a free-running microsecond count that advances on a tick input. The later stages follow one another without a wait.

Each request on `kick` picks one of two modes through `kick_block`. In blocking mode the sequencer runs to done without further help. In poll mode it takes the initial stage, then each following stage whose deadline has already passed, one per clock. It stops at the first stage that is not yet due and does nothing more until the next poll. Four of the enables are optional. If an enable's flag is low, that stage still runs and its wait still applies, but the output stays low. The PWM stage always fires and presents a fixed frequency, duty and divider setting to the external PWM generator.

Top module: `pps_panel_seq`

## Requirements
- R1: Outputs rise in this fixed order: `panel_pwr_en`, `lvds_run`, `bl_pwr_en`, `pwm_en`, `bl_en`. Each one, once high, stays high until reset.
- R2: The initial stage is taken on the second rising edge after a `kick` is sampled, with no wait.
- R3: Stage index k (initial=0, panel=1, link=2, backlight supply=3) with k < NUM_DLY sets a deadline equal to the tick count at that stage plus `dly_ms` field k (bits [k*DLY_W +: DLY_W]) times US_PER_MS. The next stage is taken on the first edge at which the count has reached that deadline, and never sooner than one cycle later.
- R4: Stage indices at or above NUM_DLY (PWM=4, backlight enable=5) add no wait. `bl_en` rises one cycle after `pwm_en`, and `done` rises in the same cycle as `bl_en`.
- R5: If `panel_ok`, `link_ok`, `blpwr_ok` or `blen_ok` is low when its stage is taken, the matching output stays low. The stage timing does not change.
- R6: When the PWM stage is taken, `pwm_freq_hz` becomes 32768, `pwm_duty` becomes 0xDF and `pwm_div` becomes 1. All three are zero before that.
- R7: A `kick` with `kick_block`=1 runs through every stage to `done` with no further request.
- R8: A `kick` with `kick_block`=0 takes the initial stage and then every consecutive stage that is already due, one per cycle. It stops at the first stage not yet due. No stage advances until the next poll.
- R9: A `kick` while a run is active, or once `done` is high, has no effect. The outputs and `done` stay as they were.
- R10: The microsecond count advances only on cycles with `tick_us` high. Without ticks, no wait ever expires.
- R11: The deadline comparison is signed and safe across wraparound, so waits that span the rollover of the TIME_W-bit count are kept exactly.
- R12: After reset, every output is low and `done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_us | input | 1 | One-microsecond timebase strobe |
| kick | input | 1 | Run request strobe |
| kick_block | input | 1 | Mode for the request: 1 runs to done, 0 polls |
| dly_ms | input | NUM_DLY*DLY_W | Per-stage waits in milliseconds, field k for stage index k |
| panel_ok | input | 1 | Panel supply enable is fitted |
| link_ok | input | 1 | LVDS shutdown release is fitted |
| blpwr_ok | input | 1 | Backlight supply enable is fitted |
| blen_ok | input | 1 | Backlight enable is fitted |
| panel_pwr_en | output | 1 | Panel supply enable |
| lvds_run | output | 1 | LVDS shutdown released |
| bl_pwr_en | output | 1 | Backlight supply enable |
| pwm_en | output | 1 | Start backlight PWM |
| bl_en | output | 1 | Backlight enable |
| pwm_freq_hz | output | 32 | PWM frequency setting |
| pwm_duty | output | 8 | PWM duty code |
| pwm_div | output | 8 | PWM clock divider |
| done | output | 1 | Sequence complete |

## Verification
The bench sets US_PER_MS to 10, so a one-millisecond wait lasts ten ticks and each full sequence finishes within about a hundred cycles. It sets DLY_W to 8 and starts the count at 0xFFFF_FFE0 after every reset. With that start value, the table-driven runs cross the 32-bit rollover partway through their waits, which exercises the wrap-safe comparison. Holding `tick_us` high makes one tick equal one cycle, so each rise time can be predicted to the exact cycle. Separate directed runs hold `tick_us` low to freeze the count, and split poll bursts across deadlines.

// File: rtl/pps_pkg.sv
`timescale 1ns/1ps
package pps_pkg;

    typedef enum logic [2:0] {
        ST_START = 3'd0,
        ST_PANEL = 3'd1,
        ST_LINK  = 3'd2,
        ST_BLPWR = 3'd3,
        ST_PWM   = 3'd4,
        ST_BLEN  = 3'd5,
        ST_DONE  = 3'd6
    } stage_e;

    typedef struct packed {
        logic blen;
        logic pwm;
        logic blpwr;
        logic link;
        logic panel;
    } rails_t;

    typedef struct packed {
        logic [31:0] freq_hz;
        logic [7:0]  duty;
        logic [7:0]  div;
    } pwm_cfg_t;

    function automatic stage_e next_stage(input stage_e s);
        return (s == ST_DONE) ? ST_DONE : stage_e'(s + 3'd1);
    endfunction

endpackage

// File: rtl/pps_timebase.sv
`timescale 1ns/1ps
module pps_timebase #(
    parameter int              TIME_W    = 32,
    parameter logic [TIME_W-1:0] TIME_INIT = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    output logic [TIME_W-1:0] now
);

    always_ff @(posedge clk) begin
        if (rst)       now <= TIME_INIT;
        else if (tick) now <= now + 1'b1;
    end

    AST_FROZEN_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        !tick |=> (now == $past(now)));  // R10

endmodule

// File: rtl/pps_deadline.sv
`timescale 1ns/1ps
module pps_deadline
    import pps_pkg::*;
#(
    parameter int TIME_W    = 32,
    parameter int DLY_W     = 16,
    parameter int NUM_DLY   = 4,
    parameter int US_PER_MS = 1000
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     arm,
    input  stage_e                   arm_stage,
    input  logic [NUM_DLY*DLY_W-1:0] dly_ms,
    input  logic [TIME_W-1:0]        now,
    output logic                     due
);

    localparam logic [TIME_W-1:0] SCALE = TIME_W'(US_PER_MS);

    logic [TIME_W-1:0] slot_us [NUM_DLY];
    logic [TIME_W-1:0] add_us;
    logic [TIME_W-1:0] deadline_q;
    logic [TIME_W-1:0] gap;

    // Per-slot wait in microseconds
    for (genvar g = 0; g < NUM_DLY; g++) begin : g_slot
        assign slot_us[g] = TIME_W'(dly_ms[g*DLY_W +: DLY_W]) * SCALE;
    end

    // Stages beyond the table add nothing
    always_comb begin
        add_us = '0;
        for (int k = 0; k < NUM_DLY; k++) begin
            if (int'(arm_stage) == k) add_us = slot_us[k];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)      deadline_q <= '0;
        else if (arm) deadline_q <= now + add_us;
    end

    // Signed distance to the deadline survives counter rollover
    assign gap = deadline_q - now;
    assign due = gap[TIME_W-1] || (gap == '0);

    AST_ARM_LATE_STAGE: assert property (@(posedge clk) disable iff (rst)
        (arm && int'(arm_stage) >= NUM_DLY) |=> due);  // R4

endmodule

// File: rtl/pps_stepper.sv
`timescale 1ns/1ps
module pps_stepper
    import pps_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   kick,
    input  logic   kick_block,
    input  logic   due,
    output stage_e stage,
    output logic   take
);

    logic blk_q;
    logic brst_q;
    logic idle;
    logic running;

    assign idle    = !blk_q && !brst_q;
    assign running = blk_q || brst_q;
    assign take    = running && (stage != ST_DONE) && ((stage == ST_START) || due);

    always_ff @(posedge clk) begin
        if (rst) begin
            stage  <= ST_START;
            blk_q  <= 1'b0;
            brst_q <= 1'b0;
        end else begin
            if (take) stage <= next_stage(stage);
            if (idle && kick && stage != ST_DONE) begin
                blk_q  <= kick_block;
                brst_q <= !kick_block;
            end else if (take && next_stage(stage) == ST_DONE) begin
                blk_q  <= 1'b0;
                brst_q <= 1'b0;
            end else if (brst_q && !take) begin
                brst_q <= 1'b0;
            end
        end
    end

    AST_ONE_MODE: assert property (@(posedge clk) disable iff (rst)
        !(blk_q && brst_q));  // R8

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        (stage == ST_DONE) |=> (stage == ST_DONE));  // R9

    AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (rst)
        (stage != $past(stage)) |-> (stage == next_stage($past(stage))));  // R1

    AST_NO_EARLY: assert property (@(posedge clk) disable iff (rst)
        (stage != ST_START && !due) |=> $stable(stage));  // R3

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (idle && !kick) |=> $stable(stage));  // R8

endmodule

// File: rtl/pps_rails.sv
`timescale 1ns/1ps
module pps_rails
    import pps_pkg::*;
#(
    parameter int         PWM_FREQ_HZ = 32768,
    parameter logic [7:0] PWM_DUTY    = 8'hDF,
    parameter logic [7:0] PWM_DIV     = 8'd1
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     take,
    input  stage_e   stage,
    input  logic     panel_ok,
    input  logic     link_ok,
    input  logic     blpwr_ok,
    input  logic     blen_ok,
    output rails_t   rails,
    output pwm_cfg_t cfg
);

    logic [4:0] rv;
    assign rv = rails;

    always_ff @(posedge clk) begin
        if (rst) begin
            rails <= '0;
            cfg   <= '0;
        end else if (take) begin
            case (stage)
                ST_PANEL: if (panel_ok) rails.panel <= 1'b1;
                ST_LINK:  if (link_ok)  rails.link  <= 1'b1;
                ST_BLPWR: if (blpwr_ok) rails.blpwr <= 1'b1;
                ST_PWM: begin
                    rails.pwm   <= 1'b1;
                    cfg.freq_hz <= 32'(PWM_FREQ_HZ);
                    cfg.duty    <= PWM_DUTY;
                    cfg.div     <= PWM_DIV;
                end
                ST_BLEN:  if (blen_ok)  rails.blen  <= 1'b1;
                default: ;
            endcase
        end
    end

    AST_RAIL_LATCH: assert property (@(posedge clk) disable iff (rst)
        ((rv & $past(rv)) == $past(rv)));  // R1

    AST_BLEN_NEEDS_PWM: assert property (@(posedge clk) disable iff (rst)
        rails.blen |-> rails.pwm);  // R1

    AST_CFG_ZERO_BEFORE_PWM: assert property (@(posedge clk) disable iff (rst)
        !rails.pwm |-> (cfg == '0));  // R6

endmodule

// File: rtl/pps_panel_seq.sv
`timescale 1ns/1ps
module pps_panel_seq
    import pps_pkg::*;
#(
    parameter int                TIME_W      = 32,
    parameter int                DLY_W       = 16,
    parameter int                NUM_DLY     = 4,
    parameter int                US_PER_MS   = 1000,
    parameter logic [TIME_W-1:0] TIME_INIT   = '0,
    parameter int                PWM_FREQ_HZ = 32768,
    parameter logic [7:0]        PWM_DUTY    = 8'hDF,
    parameter logic [7:0]        PWM_DIV     = 8'd1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     tick_us,
    input  logic                     kick,
    input  logic                     kick_block,
    input  logic [NUM_DLY*DLY_W-1:0] dly_ms,
    input  logic                     panel_ok,
    input  logic                     link_ok,
    input  logic                     blpwr_ok,
    input  logic                     blen_ok,
    output logic                     panel_pwr_en,
    output logic                     lvds_run,
    output logic                     bl_pwr_en,
    output logic                     pwm_en,
    output logic                     bl_en,
    output logic [31:0]              pwm_freq_hz,
    output logic [7:0]               pwm_duty,
    output logic [7:0]               pwm_div,
    output logic                     done
);

    logic [TIME_W-1:0] now;
    logic              due;
    logic              take;
    stage_e            stage;
    rails_t            rails;
    pwm_cfg_t          cfg;

    pps_timebase #(
        .TIME_W   (TIME_W),
        .TIME_INIT(TIME_INIT)
    ) u_time (
        .clk (clk),
        .rst (rst),
        .tick(tick_us),
        .now (now)
    );

    pps_deadline #(
        .TIME_W   (TIME_W),
        .DLY_W    (DLY_W),
        .NUM_DLY  (NUM_DLY),
        .US_PER_MS(US_PER_MS)
    ) u_dl (
        .clk      (clk),
        .rst      (rst),
        .arm      (take),
        .arm_stage(stage),
        .dly_ms   (dly_ms),
        .now      (now),
        .due      (due)
    );

    pps_stepper u_step (
        .clk       (clk),
        .rst       (rst),
        .kick      (kick),
        .kick_block(kick_block),
        .due       (due),
        .stage     (stage),
        .take      (take)
    );

    pps_rails #(
        .PWM_FREQ_HZ(PWM_FREQ_HZ),
        .PWM_DUTY   (PWM_DUTY),
        .PWM_DIV    (PWM_DIV)
    ) u_rails (
        .clk     (clk),
        .rst     (rst),
        .take    (take),
        .stage   (stage),
        .panel_ok(panel_ok),
        .link_ok (link_ok),
        .blpwr_ok(blpwr_ok),
        .blen_ok (blen_ok),
        .rails   (rails),
        .cfg     (cfg)
    );

    assign panel_pwr_en = rails.panel;
    assign lvds_run     = rails.link;
    assign bl_pwr_en    = rails.blpwr;
    assign pwm_en       = rails.pwm;
    assign bl_en        = rails.blen;
    assign pwm_freq_hz  = cfg.freq_hz;
    assign pwm_duty     = cfg.duty;
    assign pwm_div      = cfg.div;
    assign done         = (stage == ST_DONE);

    AST_DONE_AFTER_PWM: assert property (@(posedge clk) disable iff (rst)
        done |-> pwm_en);  // R4

    AST_DONE_NEEDS_ORDER: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(pwm_en));  // R4

endmodule

// File: tb/pps_panel_seq_test.sv
`timescale 1ns/1ps
module pps_panel_seq_test;

    localparam int ROWS = 4;
    localparam logic [7:0] ROW_D [ROWS][4] = '{
        '{8'd1, 8'd2, 8'd0, 8'd3},
        '{8'd0, 8'd0, 8'd0, 8'd0},
        '{8'd3, 8'd1, 8'd2, 8'd1},
        '{8'd2, 8'd0, 8'd1, 8'd0}
    };
    // ok bits: [0] panel, [1] link, [2] backlight supply, [3] backlight enable
    localparam logic [3:0] ROW_OK [ROWS] = '{4'b1111, 4'b1010, 4'b0101, 4'b0000};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_us = 1'b1;
    logic        kick = 1'b0;
    logic        kick_block = 1'b0;
    logic [31:0] dly_ms = '0;
    logic        panel_ok = 1'b1, link_ok = 1'b1, blpwr_ok = 1'b1, blen_ok = 1'b1;
    logic        panel_pwr_en, lvds_run, bl_pwr_en, pwm_en, bl_en, done;
    logic [31:0] pwm_freq_hz;
    logic [7:0]  pwm_duty, pwm_div;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int t0 = 0;
    int tr [6];
    bit finished = 1'b0;

    pps_panel_seq #(
        .TIME_W   (32),
        .DLY_W    (8),
        .NUM_DLY  (4),
        .US_PER_MS(10),
        .TIME_INIT(32'hFFFF_FFE0)
    ) uut (
        .clk(clk), .rst(rst), .tick_us(tick_us), .kick(kick), .kick_block(kick_block),
        .dly_ms(dly_ms), .panel_ok(panel_ok), .link_ok(link_ok), .blpwr_ok(blpwr_ok),
        .blen_ok(blen_ok), .panel_pwr_en(panel_pwr_en), .lvds_run(lvds_run),
        .bl_pwr_en(bl_pwr_en), .pwm_en(pwm_en), .bl_en(bl_en), .pwm_freq_hz(pwm_freq_hz),
        .pwm_duty(pwm_duty), .pwm_div(pwm_div), .done(done)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        kick = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse(input logic blk);
        @(negedge clk);
        kick = 1'b1;
        kick_block = blk;
        @(negedge clk);
        kick = 1'b0;
    endtask

    task automatic run_rec(input logic blk, input int limit);
        logic [5:0] v;
        for (int j = 0; j < 6; j++) tr[j] = -1;
        @(negedge clk);
        kick = 1'b1;
        kick_block = blk;
        t0 = cyc;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            kick = 1'b0;
            v = {done, bl_en, pwm_en, bl_pwr_en, lvds_run, panel_pwr_en};
            for (int j = 0; j < 6; j++)
                if (v[j] && tr[j] < 0) tr[j] = cyc - t0;
        end
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL R7 watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        int e [6];
        int m [4];
        int c2;
        int rise;
        logic en;

        do_reset();
        // R12 reset state
        chk("R12", "outputs after reset",
            int'({panel_pwr_en, lvds_run, bl_pwr_en, pwm_en, bl_en, done}), 0);
        chk("R12", "pwm duty after reset", int'(pwm_duty), 0);

        // Table walk: blocking runs; count starts 32 ticks before rollover (R11)
        for (int r = 0; r < ROWS; r++) begin
            dly_ms   = {ROW_D[r][3], ROW_D[r][2], ROW_D[r][1], ROW_D[r][0]};
            panel_ok = ROW_OK[r][0];
            link_ok  = ROW_OK[r][1];
            blpwr_ok = ROW_OK[r][2];
            blen_ok  = ROW_OK[r][3];
            tick_us  = 1'b1;
            do_reset();
            run_rec(1'b1, 160);
            for (int k = 0; k < 4; k++)
                m[k] = (ROW_D[r][k] == 8'd0) ? 1 : int'(ROW_D[r][k]) * 10;
            e[0] = 2 + m[0];          // R2 plus first wait
            e[1] = e[0] + m[1];
            e[2] = e[1] + m[2];
            e[3] = e[2] + m[3];
            e[4] = e[3] + 1;          // R4
            e[5] = e[4];              // R4 done with bl_en
            for (int j = 0; j < 6; j++) begin
                case (j)
                    0: en = ROW_OK[r][0];
                    1: en = ROW_OK[r][1];
                    2: en = ROW_OK[r][2];
                    4: en = ROW_OK[r][3];
                    default: en = 1'b1;
                endcase
                if (en)
                    chk((j >= 3) ? "R4 R11" : "R1 R3 R11", $sformatf("row %0d rise %0d", r, j), tr[j], e[j]);
                else
                    chk("R5", $sformatf("row %0d suppressed %0d", r, j), tr[j], -1);
            end
            chk("R7", $sformatf("row %0d done", r), int'(done), 1);
            chk("R6", $sformatf("row %0d duty", r), int'(pwm_duty), 'hDF);
            chk("R6", $sformatf("row %0d div", r), int'(pwm_div), 1);
            chk("R6", $sformatf("row %0d freq", r), int'(pwm_freq_hz), 32768);
        end

        // R8 poll mode split across deadlines
        panel_ok = 1'b1; link_ok = 1'b1; blpwr_ok = 1'b1; blen_ok = 1'b1;
        dly_ms = {8'd0, 8'd3, 8'd0, 8'd2};
        tick_us = 1'b1;
        do_reset();
        pulse(1'b0);
        repeat (40) @(negedge clk);
        chk("R8", "no progress without poll", int'(panel_pwr_en), 0);
        pulse(1'b0);
        repeat (10) @(negedge clk);
        chk("R8", "second poll panel", int'(panel_pwr_en), 1);
        chk("R8", "second poll link", int'(lvds_run), 1);
        chk("R8", "second poll stops at blpwr", int'(bl_pwr_en), 0);
        repeat (40) @(negedge clk);
        chk("R8", "blpwr waits for poll", int'(bl_pwr_en), 0);
        pulse(1'b0);
        repeat (10) @(negedge clk);
        chk("R8", "third poll done", int'(done), 1);
        chk("R8", "third poll bl_en", int'(bl_en), 1);

        // R9 kick after done ignored
        pulse(1'b1);
        repeat (30) @(negedge clk);
        chk("R9", "done held", int'(done), 1);
        chk("R9", "rails held",
            int'({panel_pwr_en, lvds_run, bl_pwr_en, pwm_en, bl_en}), 'h1F);
        chk("R9", "duty held", int'(pwm_duty), 'hDF);

        // R10 no ticks, no progress
        dly_ms = {8'd0, 8'd0, 8'd0, 8'd1};
        do_reset();
        tick_us = 1'b0;
        pulse(1'b1);
        repeat (50) @(negedge clk);
        chk("R10", "frozen without tick", int'(panel_pwr_en), 0);
        @(negedge clk);
        tick_us = 1'b1;
        c2 = cyc;
        rise = -1;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (panel_pwr_en && rise < 0) rise = cyc - c2;
        end
        chk("R10", "panel after ticks resume", rise, 11);
        chk("R10", "done after ticks resume", int'(done), 1);

        finish_run();
    end

endmodule